// File: doc/BRIEF.md
# Credit-Throttled Configuration Block Streamer

This block moves a configuration image from a 32-bit word stream into a device's configuration data register through a single register-access port. The image is cut into fixed-size blocks. In credit mode, before each block the streamer reads an 8-bit credit byte from the same port. It sends the block only when the credit byte differs from the low byte of its own count of blocks sent. In legacy mode every word is its own block and no credit is read.

While it waits for credit, the streamer re-reads the credit byte at a fixed interval and checks the device status word between reads. It gives up with a timeout after a set number of credit reads, and aborts at once if the status word shows a configuration error. When error checking is on, the streamer also reads the status word at block ends that fall on a byte-count boundary, and once more after the last word. A final word that carries only one to three bytes is sent with its unused upper bytes cleared. A start pulse begins each image. The block ends in exactly one of three sticky outcomes: done, credit timeout or configuration abort.

Top module: `credit_block_streamer`

## Requirements
- R1: After reset, and until a start pulse arrives, the block makes no register request, holds inReady low and shows none of done, errTimeout or errConfig.
- R2: In credit mode, before each block the block reads the byte at offset 0x49, returned in regRdata[7:0]. It sends the block only if that byte minus the low 8 bits of the sent-block count is non-zero in modulo-256 arithmetic. The sent-block count is cleared by start and rises by one after each block, including a short last block.
- R3: In credit mode a block is BLOCK_WORDS words, so an image of n words costs ceil(n / BLOCK_WORDS) credit reads. In legacy mode (creditMode = 0) every word is a block and no credit read is made.
- R4: Each accepted word is written once, in stream order, to offset 0x28. inReady is low while any register access is outstanding.
- R5: inBytes gives the number of valid low-order bytes in the word: 0 means 4, and 1 to 3 mean that many. Byte lanes above the count are written as zero.
- R6: When a credit read finds no credit, the block reads the status word at offset 0x1C. If bit 19 is set, the block stops at once with errConfig.
- R7: After a status read during a credit wait finds no error, the block waits POLL_GAP cycles and reads the credit byte again. If POLL_LIMIT credit reads in a row find no credit, the block stops with errTimeout.
- R8: With errCheckEn set, at the end of any block other than the last, the block reads the status word when the total bytes sent is a multiple of CHECK_BYTES. If bit 19 is set, it stops with errConfig and accepts no further word.
- R9: With errCheckEn set, the block reads the status word once after the last word. This read replaces any boundary read at that point. With errCheckEn clear, the block makes no status read outside credit waits, and a set error bit has no effect.
- R10: done rises only after the write of the last word is acknowledged, and after the final status read when that read is enabled. done, errTimeout and errConfig are mutually exclusive, stay set until the next start, and no register request or stream acceptance occurs while one is set.
- R11: A register request keeps its address, direction and write data unchanged until the cycle in which regAck is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Pulse that begins a new image (accepted only when idle or ended) |
| creditMode | input | 1 | 1: credit-throttled blocks of BLOCK_WORDS words; 0: legacy one-word blocks |
| errCheckEn | input | 1 | Enables boundary and final status checks |
| inValid | input | 1 | Stream word valid |
| inReady | output | 1 | Stream word accepted when high with inValid |
| inData | input | 32 | Stream word, byte 0 in bits 7:0 |
| inBytes | input | 2 | Valid byte count of the word (0 = 4) |
| inLast | input | 1 | Marks the last word of the image |
| regReq | output | 1 | Register access request |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | 8 | Register window offset |
| regWdata | output | 32 | Write data |
| regAck | input | 1 | Access completes in the cycle it is high |
| regRdata | input | 32 | Read data, valid with regAck |
| done | output | 1 | Image sent successfully |
| errTimeout | output | 1 | Credit wait exhausted |
| errConfig | output | 1 | Configuration error seen in status |

## Verification
The bench goes after the points where a design can slip by one block or one byte. It checks the number of credit and status reads per image against hand-computed counts for both modes. A block counter that does not advance on the short last block, or boundary math that counts words instead of bytes, would show up as a wrong status-read count. It holds the credit byte equal to the sent count partway through an image and confirms that no write leaks out during the stall. It also exhausts the poll limit, to catch an off-by-one in the number of credit reads before timeout. It sets the error bit with checking disabled to prove that the bit is ignored, and with checking enabled to prove that the abort stops the stream after exactly one boundary of words. The trailing-byte cases check that stale upper bytes are cleared rather than passed through.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int REG_AW = 8;
  localparam int DATA_W = 32;
  localparam int LANES = DATA_W / 8;

  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_DATA = 8'h28;
  localparam logic [REG_AW-1:0] OFS_CREDIT = 8'h49;
  localparam int CFG_ERR_BIT = 19;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CREDIT,
    ST_STATUS,
    ST_GAP,
    ST_TAKE,
    ST_WRITE,
    ST_CHECK,
    ST_END
  } state_t;

  typedef struct packed {
    logic clrImage;
    logic loadWord;
    logic wordDone;
  } dpCtl_t;
endpackage

// File: rtl/cbs_datapath.sv
module cbs_datapath
  import cbs_pkg::*;
#(
  parameter int BLOCK_WORDS = 1024,
  parameter int CHECK_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              creditMode,
  input  logic [DATA_W-1:0] inData,
  input  logic [1:0]        inBytes,
  input  logic              inLast,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] wordOut,
  output logic              creditOk,
  output logic              cfgErr,
  output logic              blockEnd,
  output logic              checkDue,
  output logic              lastWord
);
  localparam int BLK_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
  localparam int CHK_W = $clog2(CHECK_BYTES);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCK_WORDS - 1);
  localparam logic [DATA_W-1:0] ERR_MASK = DATA_W'(1) << CFG_ERR_BIT;

  logic [7:0]        sentCnt;
  logic [BLK_W-1:0]  wordInBlk;
  logic [CHK_W-1:0]  byteLow;
  logic [CHK_W-1:0]  byteSum;
  logic [2:0]        nbytesIn;
  logic [2:0]        nbytesReg;
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] wordReg;
  logic              lastReg;
  logic [7:0]        creditGap;

  assign nbytesIn = (inBytes == 2'd0) ? 3'd4 : {1'b0, inBytes};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneMask[8*g +: 8] = {8{3'(g) < nbytesIn}};
  end

  assign creditGap = regRdata[7:0] - sentCnt;
  assign creditOk  = (creditGap != 8'd0);
  assign cfgErr    = |(regRdata & ERR_MASK);
  assign blockEnd  = !creditMode || (wordInBlk == BLK_LAST);
  assign byteSum   = byteLow + CHK_W'(nbytesReg);
  assign checkDue  = (byteSum == '0);
  assign lastWord  = lastReg;
  assign wordOut   = wordReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sentCnt   <= '0;
      wordInBlk <= '0;
      byteLow   <= '0;
      wordReg   <= '0;
      lastReg   <= 1'b0;
      nbytesReg <= 3'd4;
    end else begin
      if (ctl.clrImage) begin
        sentCnt   <= '0;
        wordInBlk <= '0;
        byteLow   <= '0;
        lastReg   <= 1'b0;
      end
      if (ctl.loadWord) begin
        wordReg   <= inData & laneMask;
        lastReg   <= inLast;
        nbytesReg <= nbytesIn;
      end
      if (ctl.wordDone) begin
        byteLow <= byteSum;
        if (blockEnd || lastReg) begin
          wordInBlk <= '0;
          sentCnt   <= sentCnt + 8'd1;
        end else begin
          wordInBlk <= wordInBlk + BLK_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cbs_ctrl.sv
module cbs_ctrl
  import cbs_pkg::*;
#(
  parameter int POLL_GAP = 1000,
  parameter int POLL_LIMIT = 2001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              creditMode,
  input  logic              errCheckEn,
  input  logic              inValid,
  input  logic              regAck,
  input  logic              creditOk,
  input  logic              cfgErr,
  input  logic              blockEnd,
  input  logic              checkDue,
  input  logic              lastWord,
  output dpCtl_t            dpCtl,
  output logic              inReady,
  output logic              regReq,
  output logic              regWrite,
  output logic [REG_AW-1:0] regAddr,
  output logic              done,
  output logic              errTimeout,
  output logic              errConfig
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [GW-1:0] LAST_GAP = GW'(POLL_GAP - 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(POLL_LIMIT - 1);

  state_t state, stateNext;
  logic [GW-1:0] gapCnt;
  logic [PW-1:0] pollCnt;
  logic setDone, setTo, setCfg, pollClr, pollInc;

  always_comb begin
    stateNext = state;
    dpCtl = '0;
    setDone = 1'b0;
    setTo = 1'b0;
    setCfg = 1'b0;
    pollClr = 1'b0;
    pollInc = 1'b0;
    case (state)
      ST_IDLE, ST_END: begin
        if (start) begin
          dpCtl.clrImage = 1'b1;
          pollClr = 1'b1;
          stateNext = creditMode ? ST_CREDIT : ST_TAKE;
        end
      end
      ST_CREDIT: begin
        if (regAck) begin
          if (creditOk) begin
            pollClr = 1'b1;
            stateNext = ST_TAKE;
          end else begin
            stateNext = ST_STATUS;
          end
        end
      end
      ST_STATUS: begin
        if (regAck) begin
          if (cfgErr) begin
            setCfg = 1'b1;
            stateNext = ST_END;
          end else if (pollCnt == LAST_POLL) begin
            setTo = 1'b1;
            stateNext = ST_END;
          end else begin
            stateNext = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gapCnt == LAST_GAP) begin
          pollInc = 1'b1;
          stateNext = ST_CREDIT;
        end
      end
      ST_TAKE: begin
        if (inValid) begin
          dpCtl.loadWord = 1'b1;
          stateNext = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (regAck) begin
          dpCtl.wordDone = 1'b1;
          if (lastWord) begin
            if (errCheckEn) begin
              stateNext = ST_CHECK;
            end else begin
              setDone = 1'b1;
              stateNext = ST_END;
            end
          end else if (blockEnd && errCheckEn && checkDue) begin
            stateNext = ST_CHECK;
          end else if (blockEnd && creditMode) begin
            stateNext = ST_CREDIT;
          end else begin
            stateNext = ST_TAKE;
          end
        end
      end
      ST_CHECK: begin
        if (regAck) begin
          if (cfgErr) begin
            setCfg = 1'b1;
            stateNext = ST_END;
          end else if (lastWord) begin
            setDone = 1'b1;
            stateNext = ST_END;
          end else begin
            stateNext = creditMode ? ST_CREDIT : ST_TAKE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    regReq = (state == ST_CREDIT) || (state == ST_STATUS) ||
             (state == ST_WRITE) || (state == ST_CHECK);
    regWrite = (state == ST_WRITE);
    inReady = (state == ST_TAKE);
    case (state)
      ST_CREDIT: regAddr = OFS_CREDIT;
      ST_WRITE:  regAddr = OFS_DATA;
      default:   regAddr = OFS_STATUS;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      gapCnt <= '0;
      pollCnt <= '0;
      done <= 1'b0;
      errTimeout <= 1'b0;
      errConfig <= 1'b0;
    end else begin
      state <= stateNext;
      gapCnt <= (state == ST_GAP) ? gapCnt + GW'(1) : '0;
      if (pollClr) pollCnt <= '0;
      else if (pollInc) pollCnt <= pollCnt + PW'(1);
      if (dpCtl.clrImage) begin
        done <= 1'b0;
        errTimeout <= 1'b0;
        errConfig <= 1'b0;
      end else begin
        if (setDone) done <= 1'b1;
        if (setTo) errTimeout <= 1'b1;
        if (setCfg) errConfig <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/credit_block_streamer.sv
module credit_block_streamer
  import cbs_pkg::*;
#(
  parameter int BLOCK_WORDS = 1024,
  parameter int CHECK_BYTES = 4096,
  parameter int POLL_GAP = 1000,
  parameter int POLL_LIMIT = 2001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        creditMode,
  input  logic        errCheckEn,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic [1:0]  inBytes,
  input  logic        inLast,
  output logic        regReq,
  output logic        regWrite,
  output logic [7:0]  regAddr,
  output logic [31:0] regWdata,
  input  logic        regAck,
  input  logic [31:0] regRdata,
  output logic        done,
  output logic        errTimeout,
  output logic        errConfig
);
  dpCtl_t dpCtl;
  logic creditOk, cfgErr, blockEnd, checkDue, lastWord;

  cbs_ctrl #(
    .POLL_GAP(POLL_GAP),
    .POLL_LIMIT(POLL_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .creditMode(creditMode),
    .errCheckEn(errCheckEn), .inValid(inValid), .regAck(regAck),
    .creditOk(creditOk), .cfgErr(cfgErr), .blockEnd(blockEnd),
    .checkDue(checkDue), .lastWord(lastWord), .dpCtl(dpCtl),
    .inReady(inReady), .regReq(regReq), .regWrite(regWrite),
    .regAddr(regAddr), .done(done), .errTimeout(errTimeout),
    .errConfig(errConfig)
  );

  cbs_datapath #(
    .BLOCK_WORDS(BLOCK_WORDS),
    .CHECK_BYTES(CHECK_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .creditMode(creditMode),
    .inData(inData), .inBytes(inBytes), .inLast(inLast),
    .regRdata(regRdata), .wordOut(regWdata), .creditOk(creditOk),
    .cfgErr(cfgErr), .blockEnd(blockEnd), .checkDue(checkDue),
    .lastWord(lastWord)
  );
endmodule

// File: rtl/credit_block_streamer_chk.sv
module credit_block_streamer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        creditMode,
  input logic        inReady,
  input logic        regReq,
  input logic        regWrite,
  input logic [7:0]  regAddr,
  input logic [31:0] regWdata,
  input logic        regAck,
  input logic        done,
  input logic        errTimeout,
  input logic        errConfig
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regAck |=> regReq && $stable(regAddr) && $stable(regWrite) && $stable(regWdata));

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, errTimeout, errConfig}));

  // R10
  quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || errTimeout || errConfig) |-> !regReq && !inReady);

  // R4
  no_take_during_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && regReq));

  // R4
  write_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWrite |-> regAddr == 8'h28);

  // R3
  legacy_no_credit_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regWrite && regAddr == 8'h49 |-> creditMode);
endmodule

bind credit_block_streamer credit_block_streamer_chk chk_i (
  .clk(clk), .rstN(rstN), .creditMode(creditMode), .inReady(inReady),
  .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr),
  .regWdata(regWdata), .regAck(regAck), .done(done),
  .errTimeout(errTimeout), .errConfig(errConfig)
);

// File: tb/credit_block_streamer_tb_top.sv
module credit_block_streamer_tb_top;
  localparam int BW = 4;
  localparam int CB = 16;
  localparam int PG = 3;
  localparam int PL = 5;
  localparam logic [31:0] ERR_BIT = 32'h0008_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, creditMode = 1'b0, errCheckEn = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [31:0] inData = '0;
  logic [1:0] inBytes = '0;
  logic inReady, regReq, regWrite, regAck, done, errTimeout, errConfig;
  logic [7:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic [7:0] creditVal = 8'hF0;
  logic [31:0] statusVal = '0;
  logic clrLog = 1'b0;

  int wcnt, crCnt, srCnt, badCnt;
  logic [31:0] wlog [64];
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  credit_block_streamer #(
    .BLOCK_WORDS(BW), .CHECK_BYTES(CB), .POLL_GAP(PG), .POLL_LIMIT(PL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .creditMode(creditMode),
    .errCheckEn(errCheckEn), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inBytes(inBytes), .inLast(inLast), .regReq(regReq),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck), .regRdata(regRdata), .done(done),
    .errTimeout(errTimeout), .errConfig(errConfig)
  );

  // register window model
  assign regRdata = (regAddr == 8'h49) ? {24'd0, creditVal} :
                    (regAddr == 8'h1C) ? statusVal : 32'd0;

  always @(posedge clk) begin
    if (!rstN) begin
      regAck <= 1'b0;
    end else begin
      regAck <= regReq && !regAck;
    end
    if (clrLog) begin
      wcnt <= 0; crCnt <= 0; srCnt <= 0; badCnt <= 0;
    end else if (rstN && regReq && regAck) begin
      if (regWrite) begin
        if (regAddr == 8'h28 && wcnt < 64) begin
          wlog[wcnt] <= regWdata;
          wcnt <= wcnt + 1;
        end else begin
          badCnt <= badCnt + 1;
        end
      end else if (regAddr == 8'h49) crCnt <= crCnt + 1;
      else if (regAddr == 8'h1C) srCnt <= srCnt + 1;
      else badCnt <= badCnt + 1;
    end
  end

  wire fin = done | errTimeout | errConfig;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wordVal(input int img, input int i);
    return 32'hF1E2D3C4 ^ (32'(i) << 8) ^ (32'(img) << 16);
  endfunction

  function automatic logic [31:0] maskOf(input int lb);
    return (lb >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * lb)) - 32'd1);
  endfunction

  task automatic feed(input int img, input int n, input int lb);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData = wordVal(img, i);
      inBytes = (i == n - 1) ? 2'(lb % 4) : 2'd0;
      inLast = (i == n - 1);
      while (!inReady && !fin) @(negedge clk);
      if (fin) break;
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast = 1'b0;
  endtask

  task automatic waitEnd();
    int c = 0;
    while (!fin && c < 3000) begin
      @(negedge clk);
      c++;
    end
    check(fin, "R10", "image did not end", 32'(fin), 32'd1);
  endtask

  task automatic begin_image(input bit cm, input bit ce);
    @(negedge clk);
    creditMode = cm;
    errCheckEn = ce;
    clrLog = 1'b1;
    @(negedge clk);
    clrLog = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input bit cm, input bit ce, input int img, input int n, input int lb);
    begin_image(cm, ce);
    fork
      feed(img, n, lb);
      waitEnd();
    join
  endtask

  task automatic checkWords(input string req, input int img, input int n, input int lb);
    int bad = -1;
    for (int i = 0; i < n && i < 64; i++) begin
      logic [31:0] e = wordVal(img, i) & ((i == n - 1) ? maskOf(lb) : 32'hFFFF_FFFF);
      if (bad < 0 && wlog[i] !== e) bad = i;
    end
    if (bad >= 0)
      check(1'b0, req, $sformatf("word %0d", bad), wlog[bad],
            wordVal(img, bad) & ((bad == n - 1) ? maskOf(lb) : 32'hFFFF_FFFF));
    else
      check(1'b1, req, "words", 32'd0, 32'd0);
  endtask

  typedef struct packed {
    logic       cm;
    logic       ce;
    logic [7:0] n;
    logic [2:0] lb;
    logic [7:0] expW;
    logic [7:0] expCr;
    logic [7:0] expSr;
  } vec_t;

  // R2 R3 R4 R5 R8 R9: BLOCK_WORDS=4, CHECK_BYTES=16, credit always available
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b1, 8'd10, 3'd4, 8'd10, 8'd3, 8'd3},
    '{1'b1, 1'b0, 8'd8,  3'd2, 8'd8,  8'd2, 8'd0},
    '{1'b0, 1'b1, 8'd9,  3'd1, 8'd9,  8'd0, 8'd3},
    '{1'b0, 1'b0, 8'd5,  3'd3, 8'd5,  8'd0, 8'd0},
    '{1'b1, 1'b1, 8'd4,  3'd4, 8'd4,  8'd1, 8'd1},
    '{1'b1, 1'b1, 8'd1,  3'd3, 8'd1,  8'd1, 8'd1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    clrLog = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!regReq && !inReady && !done && !errTimeout && !errConfig, "R1", "in reset",
          {27'd0, regReq, inReady, done, errTimeout, errConfig}, 32'd0);
    rstN = 1'b1;
    clrLog = 1'b0;
    repeat (4) @(negedge clk);
    check(!regReq && !inReady && !fin, "R1", "idle after reset",
          {29'd0, regReq, inReady, fin}, 32'd0);

    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      run(v.cm, v.ce, k, int'(v.n), int'(v.lb));
      check(done && !errTimeout && !errConfig, "R10", $sformatf("vec%0d outcome", k),
            {29'd0, done, errTimeout, errConfig}, 32'd4);
      check(wcnt == int'(v.expW), "R4", $sformatf("vec%0d writes", k), 32'(wcnt), 32'(v.expW));
      check(crCnt == int'(v.expCr), "R3", $sformatf("vec%0d credit reads", k), 32'(crCnt), 32'(v.expCr));
      check(srCnt == int'(v.expSr), "R8", $sformatf("vec%0d status reads (R9)", k), 32'(srCnt), 32'(v.expSr));
      check(badCnt == 0, "R4", $sformatf("vec%0d stray access", k), 32'(badCnt), 32'd0);
      checkWords("R5", k, int'(v.n), int'(v.lb));
    end

    // R7: no credit at all -> timeout after PL credit reads
    creditVal = 8'd0;
    statusVal = '0;
    run(1'b1, 1'b0, 10, 4, 4);
    check(errTimeout && !done && !errConfig, "R7", "timeout flag",
          {29'd0, done, errTimeout, errConfig}, 32'd2);
    check(crCnt == PL, "R7", "credit reads before timeout", 32'(crCnt), 32'(PL));
    check(srCnt == PL, "R6", "status reads in wait", 32'(srCnt), 32'(PL));
    check(wcnt == 0, "R2", "no write without credit", 32'(wcnt), 32'd0);
    check(!regReq && !inReady, "R10", "quiet after timeout", {30'd0, regReq, inReady}, 32'd0);

    // R6: error bit seen while waiting for credit
    statusVal = ERR_BIT;
    run(1'b1, 1'b0, 11, 4, 4);
    check(errConfig && !errTimeout && !done, "R6", "abort in wait",
          {29'd0, done, errTimeout, errConfig}, 32'd1);
    check(crCnt == 1 && srCnt == 1, "R6", "reads before abort", 32'(crCnt * 16 + srCnt), 32'h11);

    // R9: error bit ignored when checking is disabled
    creditVal = 8'hF0;
    statusVal = ERR_BIT;
    run(1'b1, 1'b0, 12, 8, 4);
    check(done && !errConfig, "R9", "error bit ignored", {30'd0, done, errConfig}, 32'd2);
    check(srCnt == 0 && wcnt == 8, "R9", "no status read, all words",
          32'(srCnt * 256 + wcnt), 32'd8);

    // R8: abort at first boundary in legacy mode
    run(1'b0, 1'b1, 13, 9, 4);
    check(errConfig && !done, "R8", "abort on boundary", {30'd0, done, errConfig}, 32'd1);
    check(wcnt == 4 && srCnt == 1, "R8", "words before abort", 32'(wcnt * 16 + srCnt), 32'h41);

    // R2: credit equal to sent count stalls, then releases
    statusVal = '0;
    creditVal = 8'd2;
    begin_image(1'b1, 1'b0);
    fork
      feed(14, 12, 4);
      begin
        int c = 0;
        while (srCnt < 2 && c < 500) begin
          @(negedge clk);
          c++;
        end
        check(wcnt == 8, "R2", "writes held during stall", 32'(wcnt), 32'd8);
        check(!fin, "R2", "still waiting", 32'(fin), 32'd0);
        creditVal = 8'd3;
        waitEnd();
      end
    join
    check(done && wcnt == 12, "R2", "completes after release", 32'(wcnt), 32'd12);
    checkWords("R4", 14, 12, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule